// File: doc/BRIEF.md
# Banked Vectored Interrupt Controller

This block gathers up to 128 level-sensitive interrupt lines (96 by default) and drives a single interrupt request towards a processor. Lines are grouped into banks of 32. Each line has a mask bit and a 6-bit priority. A global threshold can filter out lines whose priority is too weak. The block reports the number of the winning line through a small register interface that has single-cycle reads and writes.

The handler reads the active-number register, which freezes the reported line and drops the request output. It then services that line and writes the acknowledge bit, after which the controller is free to pick the next winner. Software changes the masks either by writing the whole word or through set and clear aliases that touch only the one bits. A soft reset started from the configuration register puts every piece of state back to its reset value and reports when it is done.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, offset 0x00 reads the revision byte 0x21, offset 0x14 bit 0 reads 1, every bank mask reads 0xFFFFFFFF, offset 0x40 reads 0, and irq_o is low.
- R2: Writing to the mask-set alias of bank n (0x8C + 0x20·n) sets the mask bits where the data is 1 and leaves the other bits unchanged.
- R3: Writing to the mask-clear alias of bank n (0x88 + 0x20·n) clears the mask bits where the data is 1 and leaves the other bits unchanged. A direct write to 0x84 + 0x20·n replaces the whole mask word.
- R4: Offset 0x98 + 0x20·n reads the raw lines of bank n ANDed with the inverse of that bank's mask. The threshold has no effect on this value.
- R5: The selected line is the unmasked, eligible, asserted line with the numerically smallest priority, which is bits [7:2] of its level register. Ties go to the lowest line number. Line 0 is never selected, and the value 0 means that no line is selected.
- R6: When the threshold at 0x68 (bits [5:0]) is nonzero, only lines whose priority is less than the threshold are eligible. A threshold of 0 disables the filter.
- R7: irq_o is high when an eligible line exists and no line is frozen. Reading 0x40 while it shows a nonzero value freezes that value until a write to 0x48 with bit 0 set. A write to 0x48 with bit 0 clear changes nothing.
- R8: Writing 0x10 with bit 1 set starts a soft reset. In the following cycle 0x14 bit 0 reads 0. From the cycle after that, it reads 1 and all registers hold their reset values.
- R9: 0x10 bit 0, 0x4C bit 0, 0x50 bits [1:0] and 0x68 bits [5:0] are read/write. The level register of line i at 0x100 + 4·i stores bits [7:2], and its other bits read 0.
- R10: Offsets that are unmapped, misaligned, or belong to a bank or line beyond the configured count read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| irq_i | input | NUM_LINES | Level-sensitive interrupt lines |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The selection logic is driven with line sets that separate the ordering rules. A strict priority difference (line 6 with priority 1 beats line 5 with priority 3) shows that priority outranks line number. An equal-priority pair shows that the lower number wins the tie. A lone line 0 shows that it is never reported.

Threshold values of 0, 2 and 4 are applied against priorities 3 and 63, which separates "filter off" from "strictly below". Line sets that change while a line is frozen, together with acknowledge writes with bit 0 clear and bit 0 set, separate the freeze from live tracking. Mask patterns with mixed one and zero bits show the difference between alias writes and whole-word writes.

// File: rtl/birq_pkg.sv
package birq_pkg;
  localparam int unsigned BANK_W = 32;
  localparam int unsigned PRIO_W = 6;
  localparam int unsigned ID_W   = 7;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [ID_W-1:0]   id_t;

  localparam logic [11:0] OFS_REV    = 12'h000;
  localparam logic [11:0] OFS_SYSCFG = 12'h010;
  localparam logic [11:0] OFS_SYSST  = 12'h014;
  localparam logic [11:0] OFS_ACTIVE = 12'h040;
  localparam logic [11:0] OFS_CTRL   = 12'h048;
  localparam logic [11:0] OFS_PROT   = 12'h04C;
  localparam logic [11:0] OFS_IDLE   = 12'h050;
  localparam logic [11:0] OFS_THR    = 12'h068;

  // offsets inside one 0x20 bank window starting at 0x80
  localparam logic [4:0] BK_MASK = 5'h04;
  localparam logic [4:0] BK_CLR  = 5'h08;
  localparam logic [4:0] BK_SET  = 5'h0C;
  localparam logic [4:0] BK_PEND = 5'h18;
endpackage

// File: rtl/birq_mask_bank.sv
module birq_mask_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         srst_i,
  input  logic         wr_i,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_o <= '1;
    else if (srst_i) mask_o <= '1;
    else if (wr_i)   mask_o <= wdata_i;
    else if (set_i)  mask_o <= mask_o | wdata_i;
    else if (clr_i)  mask_o <= mask_o & ~wdata_i;
  end
endmodule

// File: rtl/birq_prio_arb.sv
module birq_prio_arb
  import birq_pkg::*;
#(
  parameter int unsigned N = 96
) (
  input  logic [N-1:0]             req_i,
  input  logic [N-1:0][PRIO_W-1:0] prio_i,
  input  prio_t                    thr_i,
  output logic                     found_o,
  output id_t                      id_o
);
  prio_t best;

  // strict compare keeps the lowest index on equal priority; line 0 is reserved
  always_comb begin
    found_o = 1'b0;
    id_o    = '0;
    best    = '1;
    for (int i = 1; i < int'(N); i++) begin
      if (req_i[i] && (thr_i == '0 || prio_i[i] < thr_i) &&
          (!found_o || prio_i[i] < best)) begin
        found_o = 1'b1;
        id_o    = id_t'(i);
        best    = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import birq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 96,
  parameter logic [7:0]  REV       = 8'h21
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [11:0]          addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [NUM_LINES-1:0] irq_i,
  output logic                 irq_o
);
  localparam int unsigned NUM_BANKS = (NUM_LINES + BANK_W - 1) / BANK_W;
  localparam int unsigned PAD_W     = NUM_BANKS * BANK_W;
  localparam int unsigned LVL_W     = $clog2(NUM_LINES);

  logic wr, rd;
  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  // bank window decode
  logic       in_bank, bank_ok;
  logic [1:0] bank_idx;
  logic [4:0] bank_ofs;
  assign in_bank  = addr_i[11:7] == 5'b00001;
  assign bank_idx = addr_i[6:5];
  assign bank_ofs = addr_i[4:0];
  assign bank_ok  = in_bank && (32'(bank_idx) < NUM_BANKS);

  // level window decode
  logic [9:0]       lvl_raw, lvl_off;
  logic [LVL_W-1:0] lvl_sel;
  logic             lvl_ok;
  assign lvl_raw = addr_i[11:2];
  assign lvl_off = lvl_raw - 10'd64;
  assign lvl_sel = lvl_off[LVL_W-1:0];
  assign lvl_ok  = (addr_i[1:0] == 2'b00) && (lvl_raw >= 10'd64) &&
                   (32'(lvl_off) < NUM_LINES);

  logic  srst_q, autoidle_q, prot_q, lock_q;
  logic [1:0] idle_q;
  prio_t thr_q;
  id_t   active_q;
  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q;

  logic [NUM_BANKS-1:0][BANK_W-1:0] mask_bk, pend_bk;
  logic [PAD_W-1:0]     irq_pad;
  logic [NUM_LINES-1:0] pend_lines;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = wr && in_bank && (bank_idx == 2'(b));
    birq_mask_bank #(.W(BANK_W)) u_mask (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .srst_i (srst_q),
      .wr_i   (sel && bank_ofs == BK_MASK),
      .set_i  (sel && bank_ofs == BK_SET),
      .clr_i  (sel && bank_ofs == BK_CLR),
      .wdata_i(wdata_i),
      .mask_o (mask_bk[b])
    );
  end

  assign irq_pad    = PAD_W'(irq_i);
  assign pend_bk    = irq_pad & ~mask_bk;
  assign pend_lines = pend_bk[NUM_LINES-1:0];

  logic found;
  id_t  win_id;
  birq_prio_arb #(.N(NUM_LINES)) u_arb (
    .req_i  (pend_lines),
    .prio_i (prio_q),
    .thr_i  (thr_q),
    .found_o(found),
    .id_o   (win_id)
  );

  logic ack;
  assign ack = wr && addr_i == OFS_CTRL && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srst_q     <= 1'b0;
      autoidle_q <= 1'b0;
      prot_q     <= 1'b0;
      idle_q     <= '0;
      thr_q      <= '0;
      lock_q     <= 1'b0;
      active_q   <= '0;
    end else begin
      srst_q <= wr && addr_i == OFS_SYSCFG && wdata_i[1];
      if (srst_q) begin
        autoidle_q <= 1'b0;
        prot_q     <= 1'b0;
        idle_q     <= '0;
        thr_q      <= '0;
        lock_q     <= 1'b0;
        active_q   <= '0;
      end else begin
        if (wr && addr_i == OFS_SYSCFG) autoidle_q <= wdata_i[0];
        if (wr && addr_i == OFS_PROT)   prot_q     <= wdata_i[0];
        if (wr && addr_i == OFS_IDLE)   idle_q     <= wdata_i[1:0];
        if (wr && addr_i == OFS_THR)    thr_q      <= wdata_i[PRIO_W-1:0];
        if (ack) begin
          lock_q <= 1'b0;
        end else if (rd && addr_i == OFS_ACTIVE && !lock_q && found) begin
          lock_q   <= 1'b1;
          active_q <= win_id;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                prio_q <= '0;
    else if (srst_q)            prio_q <= '0;
    else if (wr && lvl_ok)      prio_q[lvl_sel] <= wdata_i[PRIO_W+1:2];
  end

  id_t act_num;
  assign act_num = lock_q ? active_q : win_id;
  assign irq_o   = found & ~lock_q;

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (addr_i)
        OFS_REV:    rdata_o = {24'b0, REV};
        OFS_SYSCFG: rdata_o = {31'b0, autoidle_q};
        OFS_SYSST:  rdata_o = {31'b0, ~srst_q};
        OFS_ACTIVE: rdata_o = {{(32-ID_W){1'b0}}, act_num};
        OFS_PROT:   rdata_o = {31'b0, prot_q};
        OFS_IDLE:   rdata_o = {30'b0, idle_q};
        OFS_THR:    rdata_o = {{(32-PRIO_W){1'b0}}, thr_q};
        default: begin
          if (bank_ok && bank_ofs == BK_MASK)      rdata_o = mask_bk[bank_idx];
          else if (bank_ok && bank_ofs == BK_PEND) rdata_o = pend_bk[bank_idx];
          else if (lvl_ok)
            rdata_o = {{(30-PRIO_W){1'b0}}, prio_q[lvl_sel], 2'b00};
        end
      endcase
    end
  end
endmodule

// File: rtl/banked_irq_ctrl_chk.sv
module banked_irq_ctrl_chk
  import birq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 96
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [11:0]          addr_i,
  input logic [31:0]          wdata_i,
  input logic                 irq_o,
  input logic [NUM_LINES-1:0] pend_lines,
  input logic                 found,
  input id_t                  win_id,
  input logic                 lock_q,
  input id_t                  active_q,
  input logic                 srst_q,
  input prio_t                thr_q
);
  logic ack_wr, act_rd;
  assign ack_wr = req_i && we_i && addr_i == 12'h048 && wdata_i[0];
  assign act_rd = req_i && !we_i && addr_i == 12'h040;

  assert_lock_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q && !ack_wr && !srst_q |=> lock_q && $stable(active_q));

  assert_lock_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(act_rd));

  assert_irq_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |pend_lines);

  assert_winner_pending_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found |-> pend_lines[win_id] && win_id != '0);

  assert_srst_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |=> !srst_q);

  assert_srst_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |=> !lock_q && thr_q == '0);
endmodule

bind banked_irq_ctrl banked_irq_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .irq_o     (irq_o),
  .pend_lines(pend_lines),
  .found     (found),
  .win_id    (win_id),
  .lock_q    (lock_q),
  .active_q  (active_q),
  .srst_q    (srst_q),
  .thr_q     (thr_q)
);

// File: tb/banked_irq_ctrl_tb_top.sv
module banked_irq_ctrl_tb_top;
  localparam int unsigned N = 96;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [11:0]   addr = '0;
  logic [31:0]   wdata = '0, rdata;
  logic [N-1:0]  irq = '0;
  logic          irq_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  banked_irq_ctrl #(.NUM_LINES(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_i(irq), .irq_o(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data mid-cycle
  always @(negedge clk) begin
    if (req && !we) begin
      if (exp_q.size() == 0) check("queue underrun", rdata, 32'hx);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #2;
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    req = 1; we = 0; addr = a;
    @(posedge clk); #2;
    req = 0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    #1; check(tag, {31'b0, irq_out}, {31'b0, e});
  endtask

  initial begin
    #25 rst_n = 1;
    @(posedge clk); #2;
    // R1 reset state
    chk_irq(0, "R1 irq after reset");
    rd(12'h000, 32'h21, "R1 revision");
    rd(12'h014, 32'h1, "R1 reset done");
    rd(12'h084, 32'hFFFF_FFFF, "R1 bank0 mask");
    rd(12'h0C4, 32'hFFFF_FFFF, "R1 bank2 mask");
    rd(12'h040, 32'h0, "R1 active none");
    // R10 unmapped space
    wr(12'h004, 32'h1234);
    rd(12'h004, 32'h0, "R10 unmapped word");
    wr(12'h0EC, 32'hFFFF_FFFF);
    rd(12'h0E4, 32'h0, "R10 absent bank mask");
    wr(12'h280, 32'hFC);
    rd(12'h280, 32'h0, "R10 absent line level");
    rd(12'h102, 32'h0, "R10 misaligned level");
    // R3 / R2 alias writes
    wr(12'h088, 32'hF0);
    rd(12'h084, 32'hFFFF_FF0F, "R3 clear alias");
    wr(12'h08C, 32'h10);
    rd(12'h084, 32'hFFFF_FF1F, "R2 set alias");
    wr(12'h088, 32'h0);
    wr(12'h08C, 32'h0);
    rd(12'h084, 32'hFFFF_FF1F, "R2 R3 zero bits keep mask");
    // R4 masked pending
    irq = N'(96'h2_0000_0072);
    rd(12'h098, 32'h60, "R4 bank0 pending");
    rd(12'h0B8, 32'h0, "R4 bank1 masked");
    wr(12'h0A4, 32'h0);
    rd(12'h0B8, 32'h2, "R4 R3 bank1 direct unmask");
    wr(12'h0AC, 32'hFFFF_FFFF);
    rd(12'h0A4, 32'hFFFF_FFFF, "R2 bank1 set all");
    // R9 level registers
    wr(12'h114, 32'h0C);
    wr(12'h118, 32'h04);
    wr(12'h11C, 32'hFFFF_FFFF);
    rd(12'h11C, 32'hFC, "R9 level field only");
    rd(12'h114, 32'h0C, "R9 level readback");
    // R5 / R7 priority and freeze
    chk_irq(1, "R7 irq with eligible line");
    rd(12'h040, 32'd6, "R5 best priority wins");
    chk_irq(0, "R7 irq low while frozen");
    irq = N'(96'h32);
    rd(12'h040, 32'd6, "R7 frozen after line drops");
    wr(12'h048, 32'h0);
    rd(12'h040, 32'd6, "R7 ack bit0 clear ignored");
    chk_irq(0, "R7 still frozen");
    wr(12'h048, 32'h1);
    chk_irq(1, "R7 released by ack");
    rd(12'h040, 32'd5, "R5 next winner");
    wr(12'h048, 32'h1);
    wr(12'h118, 32'h0C);
    irq = N'(96'h72);
    rd(12'h040, 32'd5, "R5 tie lowest number");
    wr(12'h048, 32'h1);
    // R5 line 0 reserved
    irq = N'(96'h1);
    wr(12'h088, 32'h1);
    rd(12'h098, 32'h1, "R4 line0 pending visible");
    chk_irq(0, "R5 line0 no request");
    rd(12'h040, 32'h0, "R5 line0 never selected");
    // R6 threshold
    irq = N'(96'h80);
    chk_irq(1, "R6 threshold zero no filter");
    wr(12'h068, 32'h2);
    chk_irq(0, "R6 prio63 filtered");
    rd(12'h040, 32'h0, "R6 nothing eligible");
    irq = N'(96'hA0);
    chk_irq(0, "R6 prio3 not below 2");
    wr(12'h068, 32'h4);
    chk_irq(1, "R6 prio3 below 4");
    rd(12'h040, 32'd5, "R6 eligible winner");
    wr(12'h048, 32'h1);
    rd(12'h068, 32'h4, "R9 threshold readback");
    // R9 misc registers
    wr(12'h010, 32'h1);
    rd(12'h010, 32'h1, "R9 autoidle");
    wr(12'h04C, 32'hFFFF_FFFF);
    rd(12'h04C, 32'h1, "R9 protection");
    wr(12'h050, 32'hFFFF_FFFF);
    rd(12'h050, 32'h3, "R9 idle");
    // R8 soft reset
    rd(12'h040, 32'd5, "R8 freeze before soft reset");
    wr(12'h010, 32'h2);
    rd(12'h014, 32'h0, "R8 reset in progress");
    rd(12'h014, 32'h1, "R8 reset done");
    rd(12'h010, 32'h0, "R8 config cleared");
    rd(12'h084, 32'hFFFF_FFFF, "R8 mask restored");
    rd(12'h068, 32'h0, "R8 threshold cleared");
    rd(12'h114, 32'h0, "R8 level cleared");
    rd(12'h04C, 32'h0, "R8 protection cleared");
    rd(12'h040, 32'h0, "R8 freeze cleared");
    chk_irq(0, "R8 irq low");
    check("scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule